// File: doc/BRIEF.md
# Bounded Event-Range Recognizer

This block is a clocked monitor for one element of a loose-ordering check. It watches a single event and confirms that the event occurs a bounded number of times in a row. The number of occurrences must lie between `MIN_CNT` and `MAX_CNT` inclusive. The surrounding context arrives as per-cycle strobes:

- a start strobe that arms the recognizer;
- the recognizer's own event;
- events of sibling ranges in the same group;
- stop events that close the range;
- two classes of events that must not occur while the range is being recognized: ones that belong strictly before it, and ones that belong strictly after it.

A static parameter states whether the parent group is conjunctive or disjunctive. In a disjunctive group the range may be skipped. In a conjunctive group it may not.

The verdict comes back as one of three single-cycle pulses: accepted, skipped or violated. A sticky error flag stays high from the first violation until reset. Several recognizers can be chained or grouped by surrounding logic, which is not part of this block. The same event stream can be accepted or rejected depending on the context strobes, the counted value and the group semantics.

Top module: `bounded_range_monitor`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `ok_o`, `nok_o`, `err_o` and `err_flag_o` are 0 and the recognizer is idle.
- R2: A start strobe in the idle state arms the recognizer, and the arming depends on what accompanies it:
  - with the own event, counting begins at 1;
  - with a sibling event, the recognizer waits for its first own event while a sibling range is active;
  - alone, it waits for its first own event.
- R3: While counting, each own event increments the count up to `MAX_CNT`. An own event when the count already equals `MAX_CNT` is a violation.
- R4: A stop event while counting ends the range:
  - with `ok_o` if the count is at least `MIN_CNT`;
  - with `err_o` if the count is below `MIN_CNT`.
- R5: A sibling event while counting leads to one of two outcomes:
  - if the count is at least `MIN_CNT`, it moves to a minimum-reached state, in which further sibling events are allowed, a stop event gives `ok_o`, and an own event is a violation;
  - if the count is below `MIN_CNT`, it is a violation.
- R6: An early or forbidden event in any active state is a violation. In the idle state, every strobe other than start is ignored. A start strobe in any non-idle state is ignored.
- R7: A stop event while still waiting for the first own event gives `nok_o` and returns to idle when `DISJ` = 1. It gives `err_o` when `DISJ` = 0.
- R8: The error state is absorbing. After a violation no `ok_o` or `nok_o` appears, start is ignored, and `err_flag_o` stays 1 until reset.
- R9: `ok_o`, `nok_o` and `err_o` are registered single-cycle pulses, high in the cycle after the clock edge that samples the deciding event, and at most one of them is high at a time.
- R10: After `ok_o` or `nok_o` the recognizer is idle and accepts a new start.
- R11: When several event strobes are high in the same cycle, one class is taken:
  - early or forbidden beats stop;
  - stop beats sibling;
  - sibling beats own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms the recognizer when idle |
| own_i | input | 1 | Occurrence of the counted event |
| sib_i | input | 1 | Event of a sibling range in the same group |
| stop_i | input | 1 | Event that closes this range |
| early_i | input | 1 | Event that belongs before this range |
| forbid_i | input | 1 | Event that must not occur during this range |
| ok_o | output | 1 | Range accepted (pulse) |
| nok_o | output | 1 | Range skipped in a disjunctive group (pulse) |
| err_o | output | 1 | Violation detected (pulse) |
| err_flag_o | output | 1 | Sticky violation flag |

## Verification
Two functions can fall in the same cycle:

- Termination and counting collide when a stop strobe and an own strobe arrive together in a counting state that has reached `MIN_CNT`.
- Arming and the first count collide when start arrives together with the own event.

The bench provokes both by driving the paired strobes in one cycle. A behavioural reference model that applies the stated class priority and the start rules predicts the verdict. The bench compares every output on every clock, for a disjunctive instance and for a conjunctive instance that see the same stream.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SIBWAIT,
    ST_COUNT,
    ST_MINSIB,
    ST_ERR
  } rrm_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_OWN,
    EV_SIB,
    EV_STOP,
    EV_BAD
  } rrm_ev_e;

endpackage

// File: rtl/rrm_event_decode.sv
module rrm_event_decode
  import rrm_pkg::*;
(
  input  logic    own_i,
  input  logic    sib_i,
  input  logic    stop_i,
  input  logic    early_i,
  input  logic    forbid_i,
  output rrm_ev_e ev_o
);

  // fixed priority if the one-name-per-cycle rule is broken
  always_comb begin
    if (early_i || forbid_i) ev_o = EV_BAD;
    else if (stop_i)         ev_o = EV_STOP;
    else if (sib_i)          ev_o = EV_SIB;
    else if (own_i)          ev_o = EV_OWN;
    else                     ev_o = EV_NONE;
  end

endmodule

// File: rtl/rrm_counter.sv
module rrm_counter #(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 5,
  localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set1_i,
  input  logic inc_i,
  output logic min_met_o,
  output logic at_max_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (set1_i) cnt_q <= CNT_W'(1);
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign min_met_o = (cnt_q >= CNT_W'(MIN_CNT));
  assign at_max_o  = (cnt_q == CNT_W'(MAX_CNT));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_CNT));

  p_inc_guard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !at_max_o);

  p_inc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !set1_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_ctrl_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_i, set1_i, inc_i}));

endmodule

// File: rtl/rrm_fsm.sv
module rrm_fsm
  import rrm_pkg::*;
#(
  parameter bit DISJ = 1'b1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  rrm_ev_e ev_i,
  input  logic    min_met_i,
  input  logic    at_max_i,
  output logic    clr_o,
  output logic    set1_o,
  output logic    inc_o,
  output logic    ok_o,
  output logic    nok_o,
  output logic    err_o,
  output logic    err_flag_o
);

  rrm_state_e state_q, state_d;
  logic       ok_d, nok_d, err_d;
  logic       skip_ok;

  // parent semantics picks the outcome of a stop before the first own event
  generate
    if (DISJ) begin : g_disj
      assign skip_ok = 1'b1;
    end else begin : g_conj
      assign skip_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    set1_o  = 1'b0;
    inc_o   = 1'b0;
    ok_d    = 1'b0;
    nok_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (ev_i == EV_OWN) begin
            state_d = ST_COUNT;
            set1_o  = 1'b1;
          end else if (ev_i == EV_SIB) begin
            state_d = ST_SIBWAIT;
            clr_o   = 1'b1;
          end else begin
            state_d = ST_ARMED;
            clr_o   = 1'b1;
          end
        end
      end
      ST_ARMED, ST_SIBWAIT: begin
        unique case (ev_i)
          EV_BAD:  state_d = ST_ERR;
          EV_STOP: begin
            if (skip_ok) begin
              state_d = ST_IDLE;
              nok_d   = 1'b1;
            end else begin
              state_d = ST_ERR;
            end
          end
          EV_SIB:  state_d = ST_SIBWAIT;
          EV_OWN: begin
            state_d = ST_COUNT;
            set1_o  = 1'b1;
          end
          default: ;
        endcase
      end
      ST_COUNT: begin
        unique case (ev_i)
          EV_BAD:  state_d = ST_ERR;
          EV_STOP: begin
            if (min_met_i) begin
              state_d = ST_IDLE;
              ok_d    = 1'b1;
            end else begin
              state_d = ST_ERR;
            end
          end
          EV_SIB:  state_d = min_met_i ? ST_MINSIB : ST_ERR;
          EV_OWN: begin
            if (at_max_i) state_d = ST_ERR;
            else          inc_o   = 1'b1;
          end
          default: ;
        endcase
      end
      ST_MINSIB: begin
        unique case (ev_i)
          EV_BAD, EV_OWN: state_d = ST_ERR;
          EV_STOP: begin
            state_d = ST_IDLE;
            ok_d    = 1'b1;
          end
          default: ;
        endcase
      end
      default: state_d = ST_ERR;
    endcase
    err_d = (state_d == ST_ERR) && (state_q != ST_ERR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ok_o    <= 1'b0;
      nok_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_o    <= ok_d;
      nok_o   <= nok_d;
      err_o   <= err_d;
    end
  end

  assign err_flag_o = (state_q == ST_ERR);

  p_one_verdict_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, nok_o, err_o}));

  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |=> (err_flag_o && !ok_o && !nok_o));

  p_err_with_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_flag_o);

  p_short_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && ev_i == EV_STOP && !min_met_i) |=> err_o);

  p_ok_needs_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_d) |-> min_met_i);

  p_nok_from_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nok_d) |-> (state_q == ST_ARMED || state_q == ST_SIBWAIT));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !(ok_o || nok_o || err_o));

  p_bad_errs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_ERR && ev_i == EV_BAD) |=> err_o);

endmodule

// File: rtl/bounded_range_monitor.sv
module bounded_range_monitor
  import rrm_pkg::*;
#(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 5,
  parameter bit DISJ    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic own_i,
  input  logic sib_i,
  input  logic stop_i,
  input  logic early_i,
  input  logic forbid_i,
  output logic ok_o,
  output logic nok_o,
  output logic err_o,
  output logic err_flag_o
);

  rrm_ev_e ev;
  logic    clr, set1, inc, min_met, at_max;

  rrm_event_decode u_decode (
    .own_i    (own_i),
    .sib_i    (sib_i),
    .stop_i   (stop_i),
    .early_i  (early_i),
    .forbid_i (forbid_i),
    .ev_o     (ev)
  );

  rrm_counter #(
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT)
  ) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .set1_i    (set1),
    .inc_i     (inc),
    .min_met_o (min_met),
    .at_max_o  (at_max)
  );

  rrm_fsm #(
    .DISJ (DISJ)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ev_i       (ev),
    .min_met_i  (min_met),
    .at_max_i   (at_max),
    .clr_o      (clr),
    .set1_o     (set1),
    .inc_o      (inc),
    .ok_o       (ok_o),
    .nok_o      (nok_o),
    .err_o      (err_o),
    .err_flag_o (err_flag_o)
  );

endmodule

// File: tb/bounded_range_monitor_bench.sv
module bounded_range_monitor_bench;

  localparam int LO = 2;
  localparam int HI = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, own = 1'b0, sib = 1'b0, stop = 1'b0, early = 1'b0, forbid = 1'b0;
  logic d_ok, d_nok, d_err, d_flag;
  logic c_ok, c_nok, c_err, c_flag;

  int checks = 0;
  int fails  = 0;

  // reference state: 0 idle 1 armed 2 sib-wait 3 counting 4 min-reached 5 error
  int d_st = 0, d_cnt = 0, c_st = 0, c_cnt = 0;
  bit ed_ok, ed_nok, ed_err, ec_ok, ec_nok, ec_err;

  always #5 clk = ~clk;

  bounded_range_monitor #(.MIN_CNT(LO), .MAX_CNT(HI), .DISJ(1'b1)) u_bounded_range_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .own_i(own), .sib_i(sib),
    .stop_i(stop), .early_i(early), .forbid_i(forbid),
    .ok_o(d_ok), .nok_o(d_nok), .err_o(d_err), .err_flag_o(d_flag)
  );

  bounded_range_monitor #(.MIN_CNT(LO), .MAX_CNT(HI), .DISJ(1'b0)) u_bounded_range_monitor_conj (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .own_i(own), .sib_i(sib),
    .stop_i(stop), .early_i(early), .forbid_i(forbid),
    .ok_o(c_ok), .nok_o(c_nok), .err_o(c_err), .err_flag_o(c_flag)
  );

  task automatic model(input bit disj, inout int st, inout int cnt,
                       output bit e_ok, output bit e_nok, output bit e_err);
    int ev; // 0 none 1 own 2 sib 3 stop 4 bad
    int prev;
    prev  = st;
    e_ok  = 0;
    e_nok = 0;
    if (early || forbid) ev = 4;
    else if (stop)       ev = 3;
    else if (sib)        ev = 2;
    else if (own)        ev = 1;
    else                 ev = 0;
    case (st)
      0: if (start) begin
           if (ev == 1)      begin st = 3; cnt = 1; end
           else if (ev == 2) begin st = 2; cnt = 0; end
           else              begin st = 1; cnt = 0; end
         end
      1, 2: begin
           if (ev == 4) st = 5;
           else if (ev == 3) begin
             if (disj) begin st = 0; e_nok = 1; end
             else st = 5;
           end
           else if (ev == 2) st = 2;
           else if (ev == 1) begin st = 3; cnt = 1; end
         end
      3: begin
           if (ev == 4) st = 5;
           else if (ev == 3) begin
             if (cnt >= LO) begin st = 0; e_ok = 1; end
             else st = 5;
           end
           else if (ev == 2) st = (cnt >= LO) ? 4 : 5;
           else if (ev == 1) begin
             if (cnt < HI) cnt++;
             else st = 5;
           end
         end
      4: begin
           if (ev == 4 || ev == 1) st = 5;
           else if (ev == 3) begin st = 0; e_ok = 1; end
         end
      default: st = 5;
    endcase
    e_err = (st == 5) && (prev != 5);
  endtask

  task automatic chk(input string tag, input string who, input string what,
                     input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s %s act %0b exp %0b", tag, who, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "disj", "ok",   d_ok,   ed_ok);
    chk(tag, "disj", "nok",  d_nok,  ed_nok);
    chk(tag, "disj", "err",  d_err,  ed_err);
    chk(tag, "disj", "flag", d_flag, d_st == 5);
    chk(tag, "conj", "ok",   c_ok,   ec_ok);
    chk(tag, "conj", "nok",  c_nok,  ec_nok);
    chk(tag, "conj", "err",  c_err,  ec_err);
    chk(tag, "conj", "flag", c_flag, c_st == 5);
  endtask

  // drive at negedge, model at posedge, compare at the next negedge
  task automatic step(input string tag, input bit s, input bit o, input bit sb,
                      input bit sp, input bit e, input bit f);
    start = s; own = o; sib = sb; stop = sp; early = e; forbid = f;
    @(posedge clk);
    model(1'b1, d_st, d_cnt, ed_ok, ed_nok, ed_err);
    model(1'b0, c_st, c_cnt, ec_ok, ec_nok, ec_err);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    start = 0; own = 0; sib = 0; stop = 0; early = 0; forbid = 0;
    d_st = 0; c_st = 0; d_cnt = 0; c_cnt = 0;
    ed_ok = 0; ed_nok = 0; ed_err = 0; ec_ok = 0; ec_nok = 0; ec_err = 0;
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    compare("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements act expired exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step("R1", 0, 0, 0, 0, 0, 0);
    // R6: strobes other than start are ignored in idle
    step("R6", 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R6", 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0);
    // R2/R4/R10: start with own, reach min, stop accepts
    step("R2", 1, 1, 0, 0, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    // R3/R10: full count accepted after a new start
    step("R10", 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < HI; k++) step("R3", 0, 1, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    // R7: stop while armed, then R8 absorbing error on conj instance
    step("R7", 1, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    step("R8", 1, 1, 0, 0, 0, 0);
    step("R8", 0, 1, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    // R2/R5: start with sibling, sibling wait, then counting
    do_reset();
    step("R2", 1, 0, 1, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R7", 1, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0);
    // R4: stop below minimum
    do_reset();
    step("R4", 1, 1, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    // R3: one past the maximum
    do_reset();
    step("R3", 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < HI; k++) step("R3", 0, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0);
    // R5: sibling below minimum
    do_reset();
    step("R5", 1, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0, 0);
    // R5: minimum reached, siblings allowed, stop accepts
    do_reset();
    step("R5", 1, 1, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 0, 0);
    step("R5", 1, 1, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0, 0);
    step("R5", 0, 1, 0, 0, 0, 0);
    // R6: early / forbidden while active
    do_reset();
    step("R6", 1, 0, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    do_reset();
    step("R6", 1, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1);
    do_reset();
    step("R6", 1, 1, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1);
    // R11: simultaneous strobes
    do_reset();
    step("R11", 1, 1, 0, 0, 0, 0);
    step("R11", 0, 1, 0, 0, 0, 0);
    step("R11", 0, 1, 0, 1, 0, 0);
    step("R11", 1, 1, 0, 0, 0, 0);
    step("R11", 0, 1, 1, 0, 0, 0);
    step("R11", 0, 1, 0, 0, 1, 0);
    // R6: start ignored while counting
    do_reset();
    step("R6", 1, 1, 0, 0, 0, 0);
    step("R6", 1, 0, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule